// File: doc/BRIEF.md
# GPIO controller with pin interrupts

This block is a memory-mapped general-purpose I/O peripheral for sixteen pins. A processor reaches it through a simple 32-bit register bus made of a byte address, a write enable, write data and a combinational read data path. Every bus cycle with the write enable high is one register write. The block holds an output value register and a direction register. Each can be loaded whole, or changed bit by bit through a write-one-to-set alias and a write-one-to-clear alias, so software can change one pin without a read-modify-write. Pin levels pass through a two-flop synchronizer and can be read back.

Each pin has a control word. The control word selects push-pull or open-drain drive and a 3-bit trigger code for edges or levels. A trigger event sets a sticky status bit. The status register has whole-write, set and clear aliases. All status bits are ORed into a single interrupt line. Pad multiplexing, pull-ups, alternative signal sources and interrupt vectoring are handled outside this block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the output, direction, status and all control words read as zero, every pad output enable is low and the interrupt line is low.
- R2: The output register sits at offset 0x00 and is loaded whole by a write there. A write to 0x04 sets the bits that are one in the write data. A write to 0x08 clears those bits. Both aliases read as zero.
- R3: The direction register sits at offset 0x0C, with a set alias at 0x10 and a clear alias at 0x14, and both aliases read as zero. A one makes the pin an output.
- R4: Offset 0x18 returns the pin levels through a two-flop synchronizer. A pin change made before rising edge k is visible after edge k+1. Writes to 0x18 have no effect.
- R5: The status register sits at offset 0x1C, with a set alias at 0x20 and a clear alias at 0x24. Only bits 15:0 exist, and bits 31:16 read as zero. A status bit stays set until software clears it.
- R6: The control word of pin n sits at offset 0x28+4n for n = 0..15. Bit 2 is the drive mode (1 = open drain) and bits 9:7 are the trigger code. Bit 0 (source select) always reads 0, meaning the GPIO output register, and so do all other bits.
- R7: In push-pull mode the pad output equals the output bit and the output enable equals the direction bit. In open-drain mode the pad output is 0 and the output enable is the direction bit AND NOT the output bit.
- R8: Trigger codes 001 (rising), 010 (falling) and 011 (any change) set the pin's status bit on the edge after the synchronized level changes, which is two edges after the pin first changed.
- R9: Trigger codes 100 (low level) and 101 (high level) set the status bit on every cycle while the synchronized level matches, so a clear does not last while the level holds.
- R10: When a trigger event and a software clear or whole write reach the same status bit in the same cycle, the bit ends up set.
- R11: Trigger codes 000, 110 and 111 never set a status bit.
- R12: The interrupt output is high exactly when any status bit is set. Offsets that are unaligned or outside the map read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the register access |
| busWe | input | 1 | Write strobe, one write per cycle while high |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| padIn | input | 16 | Asynchronous pin levels |
| padOut | output | 16 | Pad output values |
| padOe | output | 16 | Pad output enables |
| irq | output | 1 | Combined interrupt line |

## Verification
The assertions take for granted that the bus carries at most one register access per cycle, and that the address and write data stay stable around the rising edge they are sampled on. The interrupt line check also relies on status bits being cleared only by a bus write. The bench drives the bus and the pin levels only on falling clock edges and holds each access for exactly one cycle. A behavioural model, updated on the same rising edge, predicts the read data, the pad outputs and the interrupt line, and these are compared one time unit after every rising edge. Directed phases cover each alias, every trigger code including the two reserved ones, the level-versus-clear race and open-drain drive. A randomised phase then mixes accesses and pin toggles.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int PIN_CNT = 16;
  localparam int IDX_W   = $clog2(PIN_CNT);
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_OUT     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_OUT_SET = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OUT_CLR = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIR_SET = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DIR_CLR = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_IN      = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_ST      = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_ST_SET  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ST_CLR  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h28;
  localparam int                CTRL_END    = 'h28 + 4 * PIN_CNT;

  localparam int DRIVE_BIT = 2;
  localparam int TRIG_LO   = 7;
  localparam int TRIG_W    = 3;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_NONE = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_ANY  = 3'b011,
    TRIG_LOW  = 3'b100,
    TRIG_HIGH = 3'b101
  } trigCode_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_OUT,
    RD_DIR,
    RD_IN,
    RD_ST,
    RD_CTRL
  } rdSel_t;

  typedef struct packed {
    logic             outWr;
    logic             outSet;
    logic             outClr;
    logic             dirWr;
    logic             dirSet;
    logic             dirClr;
    logic             stWr;
    logic             stSet;
    logic             stClr;
    logic             ctrlWr;
    logic [IDX_W-1:0] ctrlIdx;
  } gpioStrobe_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
  import gpio_pkg::*;
#(
  parameter int WIDTH = PIN_CNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] syncLvl,
  output logic [WIDTH-1:0] syncPrev
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      syncLvl  <= '0;
      syncPrev <= '0;
    end else begin
      stage1   <= padIn;
      syncLvl  <= stage1;
      syncPrev <= syncLvl;
    end
  end

endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output gpioStrobe_t       stb,
  output rdSel_t            rdSel
);

  logic [ADDR_W-1:0] wordIdx;
  logic              inCtrl;
  logic              unusedIdx;

  assign wordIdx   = (busAddr - OFS_CTRL) >> 2;
  assign unusedIdx = ^wordIdx[ADDR_W-1:IDX_W];
  assign inCtrl    = (busAddr[1:0] == 2'b00) &&
                     (busAddr >= OFS_CTRL) &&
                     (int'(busAddr) < CTRL_END);

  always_comb begin
    stb         = '0;
    rdSel       = RD_ZERO;
    stb.ctrlIdx = wordIdx[IDX_W-1:0];
    case (busAddr)
      OFS_OUT:     begin rdSel = RD_OUT; stb.outWr = busWe; end
      OFS_OUT_SET: stb.outSet = busWe;
      OFS_OUT_CLR: stb.outClr = busWe;
      OFS_DIR:     begin rdSel = RD_DIR; stb.dirWr = busWe; end
      OFS_DIR_SET: stb.dirSet = busWe;
      OFS_DIR_CLR: stb.dirClr = busWe;
      OFS_IN:      rdSel = RD_IN;
      OFS_ST:      begin rdSel = RD_ST; stb.stWr = busWe; end
      OFS_ST_SET:  stb.stSet = busWe;
      OFS_ST_CLR:  stb.stClr = busWe;
      default: begin
        if (inCtrl) begin
          rdSel      = RD_CTRL;
          stb.ctrlWr = busWe;
        end
      end
    endcase
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  gpioStrobe_t        stb,
  input  rdSel_t             rdSel,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [PIN_CNT-1:0] syncLvl,
  input  logic [PIN_CNT-1:0] syncPrev,
  output logic [DATA_W-1:0]  busRdata,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] padOe,
  output logic               irq
);

  logic [PIN_CNT-1:0] outReg;
  logic [PIN_CNT-1:0] dirReg;
  logic [PIN_CNT-1:0] statReg;
  logic [PIN_CNT-1:0] statNext;
  logic [PIN_CNT-1:0] hwSet;
  logic [PIN_CNT-1:0] wBits;
  logic               driveReg [PIN_CNT];
  logic [TRIG_W-1:0]  trigReg  [PIN_CNT];
  logic               unusedWdata;

  assign wBits       = busWdata[PIN_CNT-1:0];
  assign unusedWdata = ^busWdata[DATA_W-1:PIN_CNT];

  function automatic logic trigHit(input logic [TRIG_W-1:0] code,
                                   input logic lvl, input logic prv);
    case (code)
      TRIG_RISE: trigHit = lvl & ~prv;
      TRIG_FALL: trigHit = ~lvl & prv;
      TRIG_ANY:  trigHit = lvl ^ prv;
      TRIG_LOW:  trigHit = ~lvl;
      TRIG_HIGH: trigHit = lvl;
      default:   trigHit = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outReg <= '0;
    end else if (stb.outWr) begin
      outReg <= wBits;
    end else if (stb.outSet) begin
      outReg <= outReg | wBits;
    end else if (stb.outClr) begin
      outReg <= outReg & ~wBits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirReg <= '0;
    end else if (stb.dirWr) begin
      dirReg <= wBits;
    end else if (stb.dirSet) begin
      dirReg <= dirReg | wBits;
    end else if (stb.dirClr) begin
      dirReg <= dirReg & ~wBits;
    end
  end

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        driveReg[p] <= 1'b0;
        trigReg[p]  <= '0;
      end else if (stb.ctrlWr && stb.ctrlIdx == IDX_W'(p)) begin
        driveReg[p] <= busWdata[DRIVE_BIT];
        trigReg[p]  <= busWdata[TRIG_LO +: TRIG_W];
      end
    end

    assign hwSet[p]  = trigHit(trigReg[p], syncLvl[p], syncPrev[p]);
    assign padOut[p] = driveReg[p] ? 1'b0 : outReg[p];
    assign padOe[p]  = dirReg[p] & (~driveReg[p] | ~outReg[p]);
  end

  always_comb begin
    statNext = statReg;
    if (stb.stWr) begin
      statNext = wBits;
    end else if (stb.stSet) begin
      statNext = statReg | wBits;
    end else if (stb.stClr) begin
      statNext = statReg & ~wBits;
    end
    statNext = statNext | hwSet;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statReg <= '0;
    end else begin
      statReg <= statNext;
    end
  end

  assign irq = |statReg;

  always_comb begin
    busRdata = '0;
    case (rdSel)
      RD_OUT: busRdata[PIN_CNT-1:0] = outReg;
      RD_DIR: busRdata[PIN_CNT-1:0] = dirReg;
      RD_IN:  busRdata[PIN_CNT-1:0] = syncLvl;
      RD_ST:  busRdata[PIN_CNT-1:0] = statReg;
      RD_CTRL: begin
        busRdata[DRIVE_BIT]          = driveReg[stb.ctrlIdx];
        busRdata[TRIG_LO +: TRIG_W]  = trigReg[stb.ctrlIdx];
      end
      default: busRdata = '0;
    endcase
  end

  AST_OUT_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    stb.outSet |=> ((outReg & $past(wBits)) == $past(wBits))); // R2

  AST_DIR_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    stb.dirClr |=> ((dirReg & $past(wBits)) == '0)); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.stWr || stb.stClr) |=> (($past(statReg) & ~statReg) == '0)); // R5

  AST_HW_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hwSet != '0) |=> ((statReg & $past(hwSet)) == $past(hwSet))); // R10

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [PIN_CNT-1:0] padIn,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] padOe,
  output logic               irq
);

  gpioStrobe_t        stb;
  rdSel_t             rdSel;
  logic [PIN_CNT-1:0] syncLvl;
  logic [PIN_CNT-1:0] syncPrev;

  gpio_sync #(.WIDTH(PIN_CNT)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .padIn    (padIn),
    .syncLvl  (syncLvl),
    .syncPrev (syncPrev)
  );

  gpio_bus_decode u_decode (
    .busAddr (busAddr),
    .busWe   (busWe),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  gpio_datapath u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .syncLvl  (syncLvl),
    .syncPrev (syncPrev),
    .busRdata (busRdata),
    .padOut   (padOut),
    .padOe    (padOe),
    .irq      (irq)
  );

  AST_IRQ_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(busWe)); // R12

endmodule

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] padIn = '0;
  logic [15:0] padOut;
  logic [15:0] padOe;
  logic        irq;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string curTag = "R1";

  always #2.5 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irq(irq)
  );

  // behavioural reference model
  logic [15:0] mOut, mDir, mSt, mS1, mS2, mPrev, mOd, hw;
  logic [2:0]  mTrig [16];

  function automatic logic hitOf(input logic [2:0] c, input logic l, input logic p);
    if (c == 3'd1) return l && !p;
    if (c == 3'd2) return !l && p;
    if (c == 3'd3) return l != p;
    if (c == 3'd4) return !l;
    if (c == 3'd5) return l;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mOut = 0; mDir = 0; mSt = 0; mS1 = 0; mS2 = 0; mPrev = 0; mOd = 0;
      for (int i = 0; i < 16; i++) mTrig[i] = 3'd0;
    end else begin
      for (int i = 0; i < 16; i++) hw[i] = hitOf(mTrig[i], mS2[i], mPrev[i]);
      if (busWe) begin
        case (busAddr)
          8'h00: mOut = busWdata[15:0];
          8'h04: mOut = mOut | busWdata[15:0];
          8'h08: mOut = mOut & ~busWdata[15:0];
          8'h0C: mDir = busWdata[15:0];
          8'h10: mDir = mDir | busWdata[15:0];
          8'h14: mDir = mDir & ~busWdata[15:0];
          8'h1C: mSt = busWdata[15:0];
          8'h20: mSt = mSt | busWdata[15:0];
          8'h24: mSt = mSt & ~busWdata[15:0];
          default: begin
            if (busAddr >= 8'h28 && busAddr < 8'h68 && busAddr[1:0] == 2'b00) begin
              mOd[(busAddr - 8'h28) / 4]   = busWdata[2];
              mTrig[(busAddr - 8'h28) / 4] = busWdata[9:7];
            end
          end
        endcase
      end
      mSt = mSt | hw;
      mPrev = mS2; mS2 = mS1; mS1 = padIn;
    end
  end

  function automatic logic [31:0] expRd(input logic [7:0] a);
    case (a)
      8'h00: return {16'h0, mOut};
      8'h0C: return {16'h0, mDir};
      8'h18: return {16'h0, mS2};
      8'h1C: return {16'h0, mSt};
      default: begin
        if (a >= 8'h28 && a < 8'h68 && a[1:0] == 2'b00)
          return (32'(mOd[(a - 8'h28) / 4]) << 2) | (32'(mTrig[(a - 8'h28) / 4]) << 7);
        return 32'h0;
      end
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [15:0] eOut, eOe;
      for (int i = 0; i < 16; i++) begin
        eOut[i] = mOd[i] ? 1'b0 : mOut[i];
        eOe[i]  = mDir[i] & (mOd[i] ? ~mOut[i] : 1'b1);
      end
      chk(curTag, "read data", busRdata, expRd(busAddr));
      chk("R7", "padOut", {16'h0, padOut}, {16'h0, eOut});
      chk("R7", "padOe", {16'h0, padOe}, {16'h0, eOe});
      chk("R12", "irq", {31'h0, irq}, {31'h0, (mSt != 0)});
    end
  end

  task automatic op(input logic [7:0] a, input logic we, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = we; busWdata = d;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    op(a, 1'b1, d);
  endtask

  task automatic rd(input logic [7:0] a);
    op(a, 1'b0, 32'h0);
  endtask

  task automatic pins(input logic [15:0] v);
    @(negedge clk);
    padIn = v; busWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) op(busAddr, 1'b0, 32'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    curTag = "R1";
    rd(8'h00); rd(8'h0C); rd(8'h1C); rd(8'h28); rd(8'h64);
    // R2: output register and aliases
    curTag = "R2";
    wr(8'h00, 32'h1234_A5A5); rd(8'h00);
    wr(8'h04, 32'h0000_0F00); rd(8'h00);
    wr(8'h08, 32'h0000_0005); rd(8'h00); rd(8'h04); rd(8'h08);
    // R3: direction register and aliases
    curTag = "R3";
    wr(8'h0C, 32'hFFFF_00F0); rd(8'h0C);
    wr(8'h10, 32'h0000_8001); rd(8'h0C);
    wr(8'h14, 32'h0000_00F0); rd(8'h0C); rd(8'h10); rd(8'h14);
    // R5: status register and aliases
    curTag = "R5";
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C);
    wr(8'h24, 32'h0000_F0F0); rd(8'h1C);
    wr(8'h20, 32'h0000_0F00); rd(8'h1C);
    wr(8'h1C, 32'h0); rd(8'h1C); rd(8'h20);
    // R4: synchronized input, writes ignored
    curTag = "R4";
    rd(8'h18); pins(16'hC3A5); idle(3);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18);
    pins(16'h0000); idle(3);
    // R6: control words
    curTag = "R6";
    wr(8'h28, 32'h0000_0084); rd(8'h28);
    wr(8'h34, 32'hFFFF_FFFF); rd(8'h34);
    wr(8'h64, 32'h0000_0101); rd(8'h64);
    wr(8'h34, 32'h0); wr(8'h28, 32'h0); wr(8'h64, 32'h0); rd(8'h34);
    // R7: push-pull and open-drain drive
    curTag = "R7";
    wr(8'h0C, 32'h0000_FFFF); wr(8'h00, 32'h0000_0F0F);
    for (int p = 0; p < 8; p++) wr(8'h28 + 8'(4 * p), 32'h4);
    idle(2); wr(8'h00, 32'h0000_F0F0); idle(2);
    for (int p = 0; p < 8; p++) wr(8'h28 + 8'(4 * p), 32'h0);
    // R8: edge triggers
    curTag = "R8";
    wr(8'h28, 32'd1 << 7); wr(8'h2C, 32'd2 << 7); wr(8'h30, 32'd3 << 7);
    rd(8'h1C); pins(16'h0007); idle(4);
    wr(8'h24, 32'hFFFF); rd(8'h1C); idle(2);
    pins(16'h0000); idle(4);
    wr(8'h24, 32'hFFFF); idle(2);
    pins(16'h0004); idle(4); wr(8'h24, 32'hFFFF);
    pins(16'h0000); idle(4);
    wr(8'h28, 32'h0); wr(8'h2C, 32'h0); wr(8'h30, 32'h0); wr(8'h24, 32'hFFFF); rd(8'h1C);
    // R9: level triggers
    curTag = "R9";
    wr(8'h34, 32'd5 << 7); wr(8'h38, 32'd4 << 7);
    pins(16'h0008); idle(4);
    // R10: clear during active level
    curTag = "R10";
    wr(8'h24, 32'hFFFF); rd(8'h1C); wr(8'h1C, 32'h0); rd(8'h1C);
    curTag = "R9";
    pins(16'h0010); idle(4);
    wr(8'h34, 32'h0); wr(8'h38, 32'h0); wr(8'h24, 32'hFFFF); rd(8'h1C);
    // R11: reserved and disabled codes
    curTag = "R11";
    wr(8'h3C, 32'd6 << 7); wr(8'h40, 32'd7 << 7); wr(8'h44, 32'd0);
    rd(8'h1C);
    for (int k = 0; k < 6; k++) begin pins(16'h0070 ^ (k[0] ? 16'h0070 : 16'h0)); idle(2); end
    rd(8'h1C);
    wr(8'h3C, 32'h0); wr(8'h40, 32'h0);
    // R12: unmapped and unaligned offsets
    curTag = "R12";
    wr(8'h70, 32'hFFFF_FFFF); rd(8'h70); wr(8'h2A, 32'hFFFF_FFFF); rd(8'h2A); rd(8'h28);
    rd(8'hFC); rd(8'h00); rd(8'h1C);
    // mixed random traffic
    curTag = "R8";
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 14);
      if (sel < 10) a = 8'(sel * 4);
      else if (sel < 13) a = 8'h28 + 8'(4 * $urandom_range(0, 15));
      else if (sel == 13) a = 8'h6C;
      else a = 8'h2E;
      if ($urandom_range(0, 3) == 0) pins(16'($urandom));
      op(a, ($urandom_range(0, 2) == 0), $urandom);
    end
    idle(2);
    done = 1;
    summary();
    $finish;
  end

endmodule